// File: doc/BRIEF.md
# Defect-Avoiding Column Remap Cache Controller

This block controls a small direct-mapped cache whose physical blocks sit in a grid of rows and columns. Each access selects its row directly from the low address bits. The column is not taken directly from the address. A one-bit-per-block defect map marks blocks that must not hold data. On a fill, the controller chooses a usable column in the addressed row and saves that choice next to the line's tag. Later lookups of the same line follow the saved column to the data.

The defect map is written one bit at a time through a small write port. This typically happens after a self-test at each operating point. The map may be rewritten at any time. A line whose saved column becomes defective stops hitting, so a defective block is never read. If every column of a row is defective, accesses to that row are reported as uncacheable. Such a fill allocates nothing.

Top module: `defect_remap_cache`

## Requirements
- R1: Reset clears every defect bit to "usable" and invalidates every line. After reset, `rsp_valid` is low and every lookup misses.
- R2: Every cycle with `acc_valid` high produces exactly one cycle of `rsp_valid` on the next clock edge. A cycle without an access produces no `rsp_valid`.
- R3: An access address is split as follows. The row is `acc_addr[ROW_W-1:0]`, the home column is the next `COL_W` bits, and the tag is the top `TAG_W` bits. A lookup whose tag or row differs from a filled line does not hit that line.
- R4: A map write sets (`map_bad`=1) or clears (`map_bad`=0) the defect bit of block (`map_row`, `map_col`). Accesses on later clock edges use the new value.
- R5: A fill is placed at the first usable column, searching from the home column upward modulo the column count. `rsp_col` reports the chosen column.
- R6: If all columns of the addressed row are defective, the response has `rsp_nocache`=1 and `rsp_hit`=0. A fill in this case leaves all stored lines unchanged.
- R7: A lookup hits when the line is valid, its tag matches, and its saved column is not defective. A hit returns the filled data and the saved column.
- R8: A line whose saved column is later marked defective misses on lookup.
- R9: A fill placed in a column that holds another line of the same row invalidates that other line.
- R10: A lookup miss returns `rsp_data`=0 and `rsp_col`=0. An uncacheable fill returns `rsp_col`=0.
- R11: A fill response never has `rsp_hit` set. `rsp_hit` and `rsp_nocache` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Defect map write strobe |
| map_row | input | ROW_W | Row of the defect bit to write |
| map_col | input | COL_W | Column of the defect bit to write |
| map_bad | input | 1 | New defect bit value, 1 = defective |
| acc_valid | input | 1 | Access request |
| acc_fill | input | 1 | 1 = fill, 0 = lookup |
| acc_addr | input | TAG_W+COL_W+ROW_W | Access address {tag, column, row} |
| acc_wdata | input | DATA_W | Fill data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_nocache | output | 1 | All columns of the row are defective |
| rsp_col | output | COL_W | Physical column chosen or read |
| rsp_data | output | DATA_W | Lookup data, 0 on a miss |

## Verification
The hardest case to reach is a collision. A line that was displaced by a defect into a neighbour's column is later overwritten by that neighbour's own fill, or the reverse. Reaching it needs a defect pattern that changes between two fills. The stimulus sweeps every defect pattern of each row, with the start column rotating, and never clears the lines in between. Stale lines therefore pile up and meet later placements, and a reference model predicts every resulting hit or eviction. Directed sequences then add the late-defect and uncacheable cases on top of lines that are already stored.

// File: rtl/defect_remap_cache.sv
module defect_remap_cache #(
  parameter int TAG_W  = 4,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         map_we,
  input  logic [ROW_W-1:0]             map_row,
  input  logic [COL_W-1:0]             map_col,
  input  logic                         map_bad,
  input  logic                         acc_valid,
  input  logic                         acc_fill,
  input  logic [TAG_W+COL_W+ROW_W-1:0] acc_addr,
  input  logic [DATA_W-1:0]            acc_wdata,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic                         rsp_nocache,
  output logic [COL_W-1:0]             rsp_col,
  output logic [DATA_W-1:0]            rsp_data
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int LINE_W = ROW_W + COL_W;
  localparam int LINES  = 1 << LINE_W;
  localparam int ADDR_W = TAG_W + COL_W + ROW_W;

  logic [COLS-1:0]   bad_q  [ROWS];
  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [COL_W-1:0]  pcol_q [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  wire [ROW_W-1:0] a_row = acc_addr[ROW_W-1:0];
  wire [COL_W-1:0] a_col = acc_addr[ROW_W +: COL_W];
  wire [TAG_W-1:0] a_tag = acc_addr[ADDR_W-1 -: TAG_W];

  wire [COLS-1:0]   row_bad = bad_q[a_row];
  wire [LINE_W-1:0] lidx    = {a_row, a_col};
  wire [COL_W-1:0]  st_col  = pcol_q[lidx];
  wire              hit_c   = vld_q[lidx] && (tag_q[lidx] == a_tag) && !row_bad[st_col];
  wire              do_fill = acc_valid && acc_fill;

  logic             pick_ok;
  logic [COL_W-1:0] pick_col;

  always_comb begin
    logic [COL_W-1:0] cand;
    pick_ok  = 1'b0;
    pick_col = '0;
    for (int k = COLS - 1; k >= 0; k--) begin
      cand = a_col + COL_W'(k);
      if (!row_bad[cand]) begin
        pick_ok  = 1'b1;
        pick_col = cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) bad_q[r] <= '0;
      vld_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_nocache <= 1'b0;
      rsp_col     <= '0;
      rsp_data    <= '0;
    end else begin
      if (map_we) bad_q[map_row][map_col] <= map_bad;
      for (int c = 0; c < COLS; c++) begin
        if (do_fill && pick_ok && (COL_W'(c) != a_col) &&
            (pcol_q[{a_row, COL_W'(c)}] == pick_col))
          vld_q[{a_row, COL_W'(c)}] <= 1'b0;
      end
      if (do_fill && pick_ok) vld_q[lidx] <= 1'b1;
      rsp_valid   <= acc_valid;
      rsp_hit     <= acc_valid && !acc_fill && hit_c;
      rsp_nocache <= acc_valid && !pick_ok;
      if (!acc_valid)       rsp_col <= '0;
      else if (acc_fill)    rsp_col <= pick_ok ? pick_col : '0;
      else                  rsp_col <= hit_c ? st_col : '0;
      rsp_data <= (acc_valid && !acc_fill && hit_c) ? data_q[{a_row, st_col}] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill && pick_ok) begin
      tag_q[lidx]              <= a_tag;
      pcol_q[lidx]             <= pick_col;
      data_q[{a_row, pick_col}] <= acc_wdata;
    end
  end
endmodule

module defect_remap_cache_chk #(
  parameter int TAG_W  = 4,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         map_we,
  input logic [ROW_W-1:0]             map_row,
  input logic [COL_W-1:0]             map_col,
  input logic                         map_bad,
  input logic                         acc_valid,
  input logic                         acc_fill,
  input logic [TAG_W+COL_W+ROW_W-1:0] acc_addr,
  input logic                         rsp_valid,
  input logic                         rsp_hit,
  input logic                         rsp_nocache,
  input logic [COL_W-1:0]             rsp_col,
  input logic [DATA_W-1:0]            rsp_data
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [COLS-1:0] shadow [ROWS];
  logic [COLS-1:0] seen_bad;
  logic            was_fill;
  logic            was_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) shadow[r] <= '0;
      seen_bad <= '0;
      was_fill <= 1'b0;
      was_acc  <= 1'b0;
    end else begin
      if (map_we) shadow[map_row][map_col] <= map_bad;
      seen_bad <= shadow[acc_addr[ROW_W-1:0]];
      was_fill <= acc_fill;
      was_acc  <= acc_valid;
    end
  end

  // R2
  rsp_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == was_acc);
  // R11
  fill_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid && !was_fill && !rsp_nocache);
  // R6
  nocache_all_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_nocache == (&seen_bad)));
  // R8
  used_col_usable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_nocache && (rsp_hit || was_fill)) |-> !seen_bad[rsp_col]);
  // R10
  miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
  // R10
  miss_zero_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && (!was_fill || rsp_nocache)) |-> (rsp_col == '0));
endmodule

bind defect_remap_cache defect_remap_cache_chk #(
  .TAG_W(TAG_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_row(map_row), .map_col(map_col),
  .map_bad(map_bad), .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_addr(acc_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_nocache(rsp_nocache),
  .rsp_col(rsp_col), .rsp_data(rsp_data)
);

// File: tb/defect_remap_cache_tb.sv
`timescale 1ns/1ps
module defect_remap_cache_tb_top;
  localparam int TAG_W = 4, ROW_W = 2, COL_W = 2, DATA_W = 8;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W;
  localparam int AW = TAG_W + COL_W + ROW_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic map_we = 1'b0, map_bad = 1'b0, acc_valid = 1'b0, acc_fill = 1'b0;
  logic [ROW_W-1:0] map_row = '0;
  logic [COL_W-1:0] map_col = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [DATA_W-1:0] acc_wdata = '0;
  logic rsp_valid, rsp_hit, rsp_nocache;
  logic [COL_W-1:0] rsp_col;
  logic [DATA_W-1:0] rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_bad [ROWS*COLS];
  bit m_vld [ROWS*COLS];
  int m_tag [ROWS*COLS];
  int m_pcol[ROWS*COLS];
  int m_data[ROWS*COLS];

  defect_remap_cache #(.TAG_W(TAG_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_row(map_row), .map_col(map_col),
    .map_bad(map_bad), .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_nocache(rsp_nocache), .rsp_col(rsp_col), .rsp_data(rsp_data));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int row, input int col);
    for (int k = 0; k < COLS; k++) begin
      if (!m_bad[row*COLS + (col+k)%COLS]) return (col+k)%COLS;
    end
    return -1;
  endfunction

  task automatic map_wr(input int row, input int col, input bit bad);
    map_we = 1'b1; map_row = ROW_W'(row); map_col = COL_W'(col); map_bad = bad;
    @(negedge clk);
    map_we = 1'b0;
    m_bad[row*COLS+col] = bad;
  endtask

  task automatic access(input bit fill, input int tag, input int col, input int row,
                        input int wdata, input string req);
    int l, p, e_col, e_data;
    bit e_hit, e_nc;
    l = row*COLS + col;
    p = pick(row, col);
    e_nc = (p < 0);
    e_hit = !fill && m_vld[l] && m_tag[l] == tag && !m_bad[row*COLS + m_pcol[l]];
    e_col = fill ? (e_nc ? 0 : p) : (e_hit ? m_pcol[l] : 0);
    e_data = e_hit ? m_data[row*COLS + m_pcol[l]] : 0;
    acc_valid = 1'b1; acc_fill = fill; acc_wdata = DATA_W'(wdata);
    acc_addr = {TAG_W'(tag), COL_W'(col), ROW_W'(row)};
    @(negedge clk);
    acc_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " R2 rsp_valid"}, int'(rsp_valid), 1);
    chk(rsp_hit == e_hit, {req, " R7 rsp_hit"}, int'(rsp_hit), int'(e_hit));
    chk(rsp_nocache == e_nc, {req, " R6 rsp_nocache"}, int'(rsp_nocache), int'(e_nc));
    chk(int'(rsp_col) == e_col, {req, " R5 rsp_col"}, int'(rsp_col), e_col);
    chk(int'(rsp_data) == e_data, {req, " R10 rsp_data"}, int'(rsp_data), e_data);
    if (fill && !e_nc) begin
      for (int c = 0; c < COLS; c++)
        if (c != col && m_pcol[row*COLS+c] == p) m_vld[row*COLS+c] = 0;
      m_vld[l] = 1; m_tag[l] = tag; m_pcol[l] = p; m_data[row*COLS+p] = wdata;
    end
  endtask

  task automatic clear_map();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) map_wr(r, c, 0);
  endtask

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) begin
      m_bad[i] = 0; m_vld[i] = 0; m_tag[i] = 0; m_pcol[i] = -1; m_data[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) access(0, 0, c, r, 0, "R1 empty lookup");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle no response", int'(rsp_valid), 0);

    for (int r = 0; r < ROWS; r++)
      for (int pat = 0; pat < (1 << COLS); pat++) begin
        for (int c = 0; c < COLS; c++) map_wr(r, c, pat[c]);
        for (int c = 0; c < COLS; c++)
          access(1, (pat + c) % 16, c, r, (r*37 + pat*5 + c*11 + 1) % 256, "R5 sweep fill");
        for (int c = 0; c < COLS; c++)
          access(0, (pat + c) % 16, c, r, 0, "R7 R9 sweep lookup");
        access(0, (pat + 1) % 16, 0, r, 0, "R3 tag mismatch");
      end

    clear_map();
    access(1, 5, 1, 2, 8'h5A, "R4 fill clean");
    access(0, 5, 1, 3, 0, "R3 other row");
    access(0, 5, 1, 2, 0, "R7 hit");
    map_wr(2, 1, 1);
    access(0, 5, 1, 2, 0, "R8 saved column now bad");
    map_wr(2, 1, 0);
    access(0, 5, 1, 2, 0, "R4 bit cleared again");

    access(1, 3, 2, 0, 8'hC3, "R9 fill A");
    map_wr(0, 1, 1);
    access(1, 9, 1, 0, 8'h96, "R9 fill B displaced");
    map_wr(0, 1, 0);
    access(0, 3, 2, 0, 0, "R9 A evicted");
    access(0, 9, 1, 0, 0, "R9 B kept");

    access(1, 7, 0, 1, 8'h21, "R6 prior line");
    for (int c = 0; c < COLS; c++) map_wr(1, c, 1);
    access(1, 4, 0, 1, 8'hEE, "R6 uncacheable fill");
    access(0, 7, 0, 1, 0, "R6 uncacheable lookup");
    for (int c = 0; c < COLS; c++) map_wr(1, c, 0);
    access(0, 7, 0, 1, 0, "R6 no allocation");
    access(1, 8, 3, 1, 8'h44, "R11 fill has no hit");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule